// File: doc/BRIEF.md
# Two-Wire Handshake Link with Stall Watchdog

This block carries parallel words from a producer to a consumer over a four-phase handshake that uses two control wires. A sender state machine takes a word from the load port, puts it on the bus and raises a forward "word valid" line. A receiver state machine answers on a reverse line and delivers the word to the consume port. The two machines share a clock but meet only through the bus and the two lines. Those lines are brought out as ports so that the integrating logic wires the sender's outputs to the receiver's inputs.

A mode input picks which side opens each transfer. In sender-first mode the reverse line means "word taken". In receiver-first mode it means "ready for a word", and the sender leaves the bus at zero until it sees that line. Each machine has a watchdog counter. When the partner leaves it waiting longer than `TIMEOUT` cycles, the machine abandons the transfer, returns to idle and raises a sticky error flag.

Top module: `hs_link`

## Requirements
- R1: After reset, `fwd_valid`, `rev_reply`, `cons_valid`, `err_tx` and `err_rx` are 0, `load_ready` is 1 and `fwd_bus` is 0.
- R2: Every word accepted on the load port (`load_valid` high while `load_ready` is high) appears once on `cons_data` with a one-cycle `cons_valid` pulse, in load order and unchanged, in both modes.
- R3: In sender-first mode (`rx_first`=0), once `fwd_valid` is high it stays high with a stable bus until the reverse line is seen high or the watchdog fires. The sender drops it only after it sees the reply.
- R4: In sender-first mode, the receiver keeps `rev_reply` high until it sees `fwd_valid` low, unless its watchdog fires.
- R5: In receiver-first mode (`rx_first`=1), the sender raises `fwd_valid` only after it sees the reverse line high. While it waits, `fwd_bus` stays 0.
- R6: `fwd_bus` is non-zero only while `fwd_valid` is high.
- R7: The receiver raises `rev_reply` only in a cycle after `cons_ready` was high.
- R8: If the reply does not come, `fwd_valid` stays high for exactly `TIMEOUT` cycles. The sender then drops it and sets `err_tx`.
- R9: If `fwd_valid` does not fall after a capture in sender-first mode, `rev_reply` stays high for exactly `TIMEOUT` cycles. The receiver then drops it and sets `err_rx`.
- R10: After a watchdog abort the aborting side is idle (`load_ready`=1 for the sender), and the next transfer completes normally.
- R11: `err_tx` and `err_rx` stay high until `err_clr` is high for a cycle. A new timeout in the same cycle wins over the clear.
- R12: `load_valid` has no effect while `load_ready` is low. No extra word is delivered.
- R13: `rx_first` is sampled only while the machines are idle. It must be changed only while no transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_first | input | 1 | 0: sender opens transfers; 1: receiver opens transfers |
| err_clr | input | 1 | Clears both sticky error flags |
| load_valid | input | 1 | Producer offers a word |
| load_data | input | W | Word offered by the producer |
| load_ready | output | 1 | Sender is idle and takes a word |
| fwd_valid | output | 1 | Sender side forward line: word valid on bus |
| fwd_bus | output | W | Sender side data bus, 0 when not driven |
| tx_reply_in | input | 1 | Reverse line as seen by the sender |
| rx_valid_in | input | 1 | Forward line as seen by the receiver |
| rx_bus_in | input | W | Data bus as seen by the receiver |
| rev_reply | output | 1 | Receiver side reverse line: taken / ready |
| cons_ready | input | 1 | Consumer can take a word |
| cons_valid | output | 1 | One-cycle pulse, word delivered |
| cons_data | output | W | Delivered word |
| err_tx | output | 1 | Sticky: sender watchdog fired |
| err_rx | output | 1 | Sticky: receiver watchdog fired |

## Verification
The bench holds the consumer back in both modes. A sender that gave up early or let go of the bus would lose or corrupt the word, and a receiver-first sender that drove the bus too soon would show a non-zero bus while `fwd_valid` is low. It cuts the reverse line and sticks the forward line high, then counts the cycles the stranded line stays up. An off-by-one watchdog shows as a count other than `TIMEOUT`, and a side that does not return to idle fails the recovery transfer that follows. It also offers words while the sender is busy, so a sender that took them would deliver a word the scoreboard never queued.

// File: rtl/hs_link.sv
`timescale 1ns/1ps
module hs_link #(
  parameter int W       = 8,
  parameter int TIMEOUT = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_first,
  input  logic         err_clr,
  input  logic         load_valid,
  input  logic [W-1:0] load_data,
  output logic         load_ready,
  output logic         fwd_valid,
  output logic [W-1:0] fwd_bus,
  input  logic         tx_reply_in,
  input  logic         rx_valid_in,
  input  logic [W-1:0] rx_bus_in,
  output logic         rev_reply,
  input  logic         cons_ready,
  output logic         cons_valid,
  output logic [W-1:0] cons_data,
  output logic         err_tx,
  output logic         err_rx
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  typedef enum logic [1:0] {T_IDLE, T_ARMED, T_DRIVE, T_RELEASE} tx_st_t;
  typedef enum logic [1:0] {R_IDLE, R_REQ, R_ACK, R_DONE} rx_st_t;

  tx_st_t        tx_st;
  rx_st_t        rx_st;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [W-1:0]  hold;
  logic          tx_to, rx_to;

  assign tx_to      = (tx_cnt == LAST);
  assign rx_to      = (rx_cnt == LAST);
  assign load_ready = (tx_st == T_IDLE);
  assign fwd_valid  = (tx_st == T_DRIVE);
  assign fwd_bus    = fwd_valid ? hold : '0;
  assign rev_reply  = (rx_st == R_REQ) || (rx_st == R_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st  <= T_IDLE;
      tx_cnt <= '0;
      hold   <= '0;
      err_tx <= 1'b0;
    end else begin
      if (err_clr) err_tx <= 1'b0;
      case (tx_st)
        T_IDLE: if (load_valid) begin
          hold   <= load_data;
          tx_st  <= rx_first ? T_ARMED : T_DRIVE;
          tx_cnt <= '0;
        end
        T_ARMED: if (tx_reply_in) begin
          tx_st  <= T_DRIVE;
          tx_cnt <= '0;
        end
        T_DRIVE: begin
          if (rx_first ? !tx_reply_in : tx_reply_in) begin
            tx_st  <= rx_first ? T_IDLE : T_RELEASE;
            tx_cnt <= '0;
          end else if (tx_to) begin
            tx_st  <= T_IDLE;
            err_tx <= 1'b1;
          end else begin
            tx_cnt <= tx_cnt + CW'(1);
          end
        end
        default: begin
          if (!tx_reply_in) begin
            tx_st <= T_IDLE;
          end else if (tx_to) begin
            tx_st  <= T_IDLE;
            err_tx <= 1'b1;
          end else begin
            tx_cnt <= tx_cnt + CW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st      <= R_IDLE;
      rx_cnt     <= '0;
      cons_valid <= 1'b0;
      cons_data  <= '0;
      err_rx     <= 1'b0;
    end else begin
      cons_valid <= 1'b0;
      if (err_clr) err_rx <= 1'b0;
      case (rx_st)
        R_IDLE: begin
          if (!rx_first) begin
            if (rx_valid_in && cons_ready) begin
              cons_valid <= 1'b1;
              cons_data  <= rx_bus_in;
              rx_st      <= R_ACK;
              rx_cnt     <= '0;
            end
          end else if (cons_ready) begin
            rx_st <= R_REQ;
          end
        end
        R_REQ: if (rx_valid_in) begin
          cons_valid <= 1'b1;
          cons_data  <= rx_bus_in;
          rx_st      <= R_DONE;
          rx_cnt     <= '0;
        end
        default: begin
          if (!rx_valid_in) begin
            rx_st <= R_IDLE;
          end else if (rx_to) begin
            rx_st  <= R_IDLE;
            err_rx <= 1'b1;
          end else begin
            rx_cnt <= rx_cnt + CW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hs_link_chk.sv
`timescale 1ns/1ps
module hs_link_chk #(
  parameter int W       = 8,
  parameter int TIMEOUT = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_first,
  input logic         err_clr,
  input logic         load_ready,
  input logic         fwd_valid,
  input logic [W-1:0] fwd_bus,
  input logic         tx_reply_in,
  input logic         rx_valid_in,
  input logic         rev_reply,
  input logic         cons_ready,
  input logic         cons_valid,
  input logic         err_tx,
  input logic         err_rx
);
  localparam int CW = $clog2(TIMEOUT + 1) + 1;
  logic [CW-1:0] vrun, rrun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vrun <= '0;
      rrun <= '0;
    end else begin
      vrun <= fwd_valid ? vrun + CW'(1) : '0;
      rrun <= (rev_reply && !rx_first) ? rrun + CW'(1) : '0;
    end
  end

  // R3
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_first && fwd_valid && !tx_reply_in) |=> ((fwd_valid && $stable(fwd_bus)) || err_tx));
  // R4
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_first && rev_reply && rx_valid_in) |=> (rev_reply || err_rx));
  // R5
  wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_first && $rose(fwd_valid)) |-> $past(tx_reply_in));
  // R6
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_bus != '0) |-> fwd_valid);
  // R7
  reply_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rev_reply) |-> $past(cons_ready));
  // R8
  tx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vrun <= CW'(TIMEOUT));
  // R9
  rx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rrun <= CW'(TIMEOUT));
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_tx) |-> (!fwd_valid && load_ready));
  // R11
  sticky_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_tx && !err_clr) |=> err_tx);
  // R11
  sticky_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rx && !err_clr) |=> err_rx);
  // R2
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cons_valid |=> !cons_valid);
endmodule

bind hs_link hs_link_chk #(.W(W), .TIMEOUT(TIMEOUT)) u_chk (.*);

// File: tb/tb_hs_link.sv
`timescale 1ns/1ps
module tb_hs_link;
  localparam int W  = 8;
  localparam int TO = 16;

  logic clk = 0, rst_n = 0, rx_first = 0, err_clr = 0;
  logic load_valid = 0, cons_ready = 0;
  logic [W-1:0] load_data = '0;
  logic load_ready, fwd_valid, rev_reply, cons_valid, err_tx, err_rx;
  logic [W-1:0] fwd_bus, cons_data;
  logic rev_cut = 0, fwd_stuck = 0;
  logic tx_reply_in, rx_valid_in;

  assign tx_reply_in = rev_cut ? 1'b0 : rev_reply;
  assign rx_valid_in = fwd_stuck ? 1'b1 : fwd_valid;

  hs_link #(.W(W), .TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .rx_first(rx_first), .err_clr(err_clr),
    .load_valid(load_valid), .load_data(load_data), .load_ready(load_ready),
    .fwd_valid(fwd_valid), .fwd_bus(fwd_bus), .tx_reply_in(tx_reply_in),
    .rx_valid_in(rx_valid_in), .rx_bus_in(fwd_bus), .rev_reply(rev_reply),
    .cons_ready(cons_ready), .cons_valid(cons_valid), .cons_data(cons_data),
    .err_tx(err_tx), .err_rx(err_rx));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, delivered = 0;
  bit done = 0;
  logic [W-1:0] q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] d, input bit track);
    while (!load_ready) @(negedge clk);
    load_valid = 1; load_data = d;
    if (track) q.push_back(d);
    @(negedge clk);
    load_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (q.size() != 0 || !load_ready); i++) @(negedge clk);
    chk(q.size() == 0, "R2 drain", q.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && cons_valid) begin
      delivered++;
      if (q.size() == 0) chk(0, "R12 unexpected word", cons_data, 0);
      else begin
        logic [W-1:0] e;
        e = q.pop_front();
        chk(cons_data == e, "R2 word", cons_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!fwd_valid && !rev_reply && !cons_valid, "R1 lines", {fwd_valid, rev_reply, cons_valid}, 0);
    chk(load_ready && !err_tx && !err_rx && fwd_bus == 0, "R1 idle", {load_ready, err_tx, err_rx}, 4);

    // sender-first stream
    cons_ready = 1;
    load(8'hA5, 1); load(8'h3C, 1); load(8'hFF, 1); load(8'h01, 1);
    drain();

    // R12: offer a word while busy
    n = delivered;
    load(8'h11, 1);
    chk(!load_ready, "R12 busy", load_ready, 0);
    load_valid = 1; load_data = 8'h77;
    @(negedge clk);
    load_valid = 0;
    drain();
    repeat (5) @(negedge clk);
    chk(delivered == n + 1, "R12 count", delivered - n, 1);

    // R3: consumer stalls in sender-first mode
    cons_ready = 0;
    load(8'h42, 1);
    for (int i = 0; i < 5; i++) begin
      chk(fwd_valid && fwd_bus == 8'h42, "R3 hold", fwd_bus, 8'h42);
      @(negedge clk);
    end
    cons_ready = 1;
    drain();

    // R5, R13: receiver-first mode
    rx_first = 1; cons_ready = 0;
    @(negedge clk);
    load(8'h5A, 1);
    for (int i = 0; i < 4; i++) begin
      chk(!fwd_valid && fwd_bus == 0 && !load_ready, "R5 wait", fwd_bus, 0);
      @(negedge clk);
    end
    cons_ready = 1;
    drain();
    load(8'hC3, 1); load(8'h80, 1); load(8'h7E, 1);
    drain();
    chk(!err_tx && !err_rx, "R2 no errors", {err_tx, err_rx}, 0);

    // R8: reverse line cut, sender watchdog
    cons_ready = 0;
    repeat (4) @(negedge clk);
    rx_first = 0;
    @(negedge clk);
    rev_cut = 1;
    load(8'h99, 0);
    n = 0;
    for (int i = 0; i < 100 && fwd_valid; i++) begin n++; @(negedge clk); end
    chk(n == TO, "R8 window", n, TO);
    chk(err_tx && !err_rx, "R8 flag", {err_tx, err_rx}, 2);
    chk(load_ready && !fwd_valid, "R10 idle", load_ready, 1);
    rev_cut = 0;
    repeat (5) @(negedge clk);
    chk(err_tx, "R11 sticky", err_tx, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(!err_tx, "R11 clear", err_tx, 0);

    // R9: forward line stuck high after capture
    cons_ready = 1;
    load(8'h66, 1);
    for (int i = 0; i < 20 && !cons_valid; i++) @(negedge clk);
    fwd_stuck = 1; cons_ready = 0;
    n = 0;
    for (int i = 0; i < 100 && rev_reply; i++) begin n++; @(negedge clk); end
    chk(n == TO, "R9 window", n, TO);
    chk(err_rx && !err_tx, "R9 flag", {err_tx, err_rx}, 1);
    fwd_stuck = 0;
    @(negedge clk);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(!err_rx, "R11 clear rx", err_rx, 0);

    // R10: recovery
    cons_ready = 1;
    load(8'h24, 1); load(8'hDB, 1);
    drain();
    chk(!err_tx && !err_rx, "R10 recovered", {err_tx, err_rx}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule